// File: doc/BRIEF.md
# Selective Video-Processor Wait-State Inserter

This block stretches CPU bus cycles that reach the video display processor while leaving every other memory access at full, zero-wait speed. It watches the decoded video-processor read select, and it watches writes aimed at the video processor's address port. Both are qualified by the memory-enable strobe. When a new access of either kind begins, it pulls the CPU READY line low for a fixed number of clocks.

Insertion is governed by a software-controlled enable bit from the memory mapper. With the bit clear, READY stays high and the machine behaves as if the block were absent. The main use is code running from fast RAM that writes the two address-setup bytes back to back. The stall after the first byte gives the video processor the recovery time it needs before the second byte arrives.

A wait starts on the first cycle of an access, meaning the select is active now and was inactive in the previous clock. A select that stays asserted does not restart the delay. The wait length is a parameter, `WAIT_CYCLES`, with a default of 4.

Top module: `vid_wait_inserter`

## Requirements
- R1: While reset is asserted READY is 1, whatever the inputs are. After reset is released, with no access, READY stays 1.
- R2: With `wait_enable`=1, a rising edge of (`mem_en` & `vid_rd_sel`) drives READY to 0 in that same cycle. READY then stays 0 for exactly `WAIT_CYCLES` consecutive cycles (default 4).
- R3: A select held active across several cycles triggers only one wait. Once that wait has run out, READY is 1 even though the select is still active.
- R4: A rising edge of (`mem_en` & `vid_wr_sel` & `vid_addr_port`) triggers the same wait as R2. A write with `vid_addr_port`=0 (data port) triggers no wait.
- R5: With `wait_enable`=0 and no wait in progress, READY is 1 for every input pattern.
- R6: Clearing `wait_enable` during a wait does not cut that wait short. After it ends, no new wait starts while the bit stays 0.
- R7: A select without `mem_en`=1 triggers no wait.
- R8: A new access edge that arrives while a wait is in progress neither extends nor restarts it. The next edge after the wait has ended starts a full new wait.
- R9: The internal wait counter counts down by one each cycle during a wait, and READY returns to 1 in the cycle after the counter's last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_en | input | 1 | Memory-enable strobe qualifying the selects |
| vid_rd_sel | input | 1 | Decoded video-processor read select |
| vid_wr_sel | input | 1 | Decoded video-processor write select |
| vid_addr_port | input | 1 | 1 when the write targets the address port, 0 for the data port |
| wait_enable | input | 1 | Software enable bit for wait insertion (0 after reset by the mapper) |
| ready | output | 1 | CPU READY; 0 stalls the current bus cycle |

## Verification
Several properties are checked on every clock by assertions:
- READY is high in reset.
- READY stays high whenever insertion is disabled, or the strobe is idle, and no wait is running.
- The counter steps down by exactly one while busy.
- A loaded wait holds READY low in the following cycle.

Some behaviour only the bench's scenarios can show:
- The exact length of each stall.
- The single trigger for a held select.
- The difference between address-port and data-port writes.
- Completion of a wait after the enable drops.
- That an edge arriving mid-wait is ignored.

// File: rtl/vid_wait_pkg.sv
`timescale 1ns/1ps
package vid_wait_pkg;
  // Trigger sources, one edge detector each
  localparam int SRC_READ = 0;
  localparam int SRC_ADDR = 1;
  localparam int NUM_SRC  = 2;

  // Width of a counter that holds values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Value loaded on trigger: the trigger cycle itself is the first stall cycle
  function automatic int load_value(input int wait_cycles);
    return wait_cycles - 1;
  endfunction
endpackage

// File: rtl/vid_edge_detect.sv
`timescale 1ns/1ps
module vid_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= act_i;
  end

  assign rise_o = act_i & ~prev_q;
endmodule

// File: rtl/vid_wait_counter.sv
`timescale 1ns/1ps
module vid_wait_counter #(
  parameter int WAIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o,
  output logic ready_o
);
  import vid_wait_pkg::*;
  localparam int CW = cnt_width(WAIT_CYCLES);
  localparam logic [CW-1:0] LOADV = CW'(load_value(WAIT_CYCLES));

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (load_i)    cnt_q <= LOADV;
    else if (busy_o)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o  = (cnt_q != '0);
  assign ready_o = ~(busy_o | load_i);

  // R9: a running wait steps down by exactly one each cycle
  assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (cnt_q == $past(cnt_q) - 1'b1));

  generate
    if (WAIT_CYCLES > 1) begin : g_multi
      // R2: a loaded wait keeps READY low in the following cycle
      assert_load_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !ready_o);
    end
  endgenerate
endmodule

// File: rtl/vid_wait_inserter.sv
`timescale 1ns/1ps
module vid_wait_inserter #(
  parameter int WAIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_en,
  input  logic vid_rd_sel,
  input  logic vid_wr_sel,
  input  logic vid_addr_port,
  input  logic wait_enable,
  output logic ready
);
  import vid_wait_pkg::*;

  logic [NUM_SRC-1:0] src_act;
  logic [NUM_SRC-1:0] src_rise;
  logic any_rise;
  logic start_wait;
  logic wait_busy;
  logic ready_core;

  assign src_act[SRC_READ] = mem_en & vid_rd_sel;
  assign src_act[SRC_ADDR] = mem_en & vid_wr_sel & vid_addr_port;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      vid_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (src_act[i]),
        .rise_o (src_rise[i])
      );
    end
  endgenerate

  assign any_rise   = |src_rise;
  assign start_wait = any_rise & wait_enable & ~wait_busy;

  vid_wait_counter #(.WAIT_CYCLES(WAIT_CYCLES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start_wait),
    .busy_o  (wait_busy),
    .ready_o (ready_core)
  );

  assign ready = rst_n ? ready_core : 1'b1;

  // R1: READY is released while reset is held
  assert_reset_ready_R1: assert property (@(posedge clk)
    !rst_n |-> ready);

  // R5: disabled and idle means no stall
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_enable && !wait_busy) |-> ready);

  // R7: no memory strobe and idle means no stall
  assert_no_strobe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en && !wait_busy) |-> ready);
endmodule

// File: tb/vid_wait_inserter_bench.sv
`timescale 1ns/1ps
module vid_wait_inserter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_en = 1'b0, vid_rd_sel = 1'b0, vid_wr_sel = 1'b0;
  logic vid_addr_port = 1'b0, wait_enable = 1'b0;
  logic ready;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vid_wait_inserter #(.WAIT_CYCLES(4)) u_vid_wait_inserter (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .vid_rd_sel(vid_rd_sel),
    .vid_wr_sel(vid_wr_sel), .vid_addr_port(vid_addr_port),
    .wait_enable(wait_enable), .ready(ready));

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Per cycle: {req, en, mem, rd, wr, ap, expected_ready}; wait length 4
  localparam int NV = 34;
  localparam logic [9:0] VEC [NV] = '{
    {4'd1, 6'b100001},
    {4'd2, 6'b111000}, {4'd3, 6'b111000}, {4'd3, 6'b111000}, {4'd3, 6'b111000},
    {4'd3, 6'b111001},
    {4'd9, 6'b100001},
    {4'd4, 6'b110110}, {4'd9, 6'b100000}, {4'd9, 6'b100000}, {4'd9, 6'b100000},
    {4'd9, 6'b100001},
    {4'd4, 6'b110101}, {4'd4, 6'b100001},
    {4'd7, 6'b101001}, {4'd7, 6'b100001},
    {4'd5, 6'b011001}, {4'd5, 6'b000001},
    {4'd6, 6'b110110}, {4'd6, 6'b000000}, {4'd6, 6'b000000}, {4'd6, 6'b000000},
    {4'd6, 6'b011001}, {4'd6, 6'b100001},
    {4'd8, 6'b111000}, {4'd8, 6'b100000}, {4'd8, 6'b111000}, {4'd8, 6'b100000},
    {4'd8, 6'b100001},
    {4'd8, 6'b110110}, {4'd8, 6'b100000}, {4'd8, 6'b100000}, {4'd8, 6'b100000},
    {4'd8, 6'b100001}
  };

  task automatic check(input string req, input logic exp, input int idx);
    checks++;
    if (ready !== exp) begin
      failures++;
      $display("FAIL %s step %0d: ready=%b expected=%b", req, idx, ready, exp);
    end
  endtask

  task automatic drive(input logic [4:0] s);
    {wait_enable, mem_en, vid_rd_sel, vid_wr_sel, vid_addr_port} = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 check("R1", 1'b1, -1);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][5:1]);
      #2 check(req_name(VEC[i][9:6]), VEC[i][0], i);
    end
    // Directed: reset during a running wait
    @(negedge clk);
    drive(5'b11100);
    #2 check("R2", 1'b0, 100);
    @(negedge clk);
    rst_n = 1'b0;
    #2 check("R1", 1'b1, 101);
    @(negedge clk);
    #2 check("R1", 1'b1, 102);
    drive(5'b10000);
    @(negedge clk);
    rst_n = 1'b1;
    #2 check("R1", 1'b1, 103);
    @(negedge clk);
    #2 check("R1", 1'b1, 104);
    done = 1'b1;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: ready=%b expected=completion", ready);
    end
  end

  initial begin
    wait (done);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && $time > 8 * 20000 - 1) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule